// File: doc/BRIEF.md
# Transition-Coded Handshake Link Endpoint

This block is one end of a full-duplex serial link that carries its own timing. Each direction has a pair of wires. A symbol is sent by toggling wires, not by driving a level. A data bit toggles one of the two outgoing wires. An acknowledgement (ACK) toggles both. The line has no resting value: all that matters is the current pair of levels and which of them flips next.

The two ends take turns. Every symbol received obliges the endpoint to send exactly one symbol back. Sending a data bit meets that obligation as well as an ACK does. An ACK goes out only when a reply is owed and the transmit side has no bit to offer. When neither side has data, ACKs bounce back and forth. A programmable wait slows this idle ping-pong, but it applies only when the symbol being answered was itself an ACK.

The incoming wire pair passes through a two-flop synchroniser. The endpoint then compares it with the last pair it saw. After reset, the endpoint built with `FIRST_TURN` set owes the first symbol. An endpoint built with it clear waits for the peer to send first.

Top module: `tclink_endpoint`

## Requirements
- R1: While reset is held, `tx_wires` reads 00, `rx_valid` and `rx_ack` read 0, and `tx_ready` equals `FIRST_TURN` (1 by default).
- R2: Sending data bit 0 toggles only `tx_wires[0]`. Sending data bit 1 toggles only `tx_wires[1]`. The toggle appears at the clock edge that completes the `tx_valid`/`tx_ready` handshake.
- R3: An ACK toggles both `tx_wires` bits in the same cycle.
- R4: When no reply is owed, `tx_ready` is 0 and `tx_wires` does not change, even if `tx_valid` is held high.
- R5: When only `rx_wires[0]` flips, `rx_valid` pulses for one cycle with `rx_bit`=0. When only `rx_wires[1]` flips, the pulse carries `rx_bit`=1. The pulse is visible after the third rising edge that follows the change, and not before.
- R6: When both `rx_wires` bits flip together, `rx_ack` pulses with the same timing as R5 and `rx_valid` stays 0.
- R7: A received symbol makes a reply owed. `tx_ready` rises in the same cycle as the R5/R6 pulse.
- R8: If `tx_valid` is high while a reply is owed, the reply is the data bit and never an ACK, whatever the delay setting.
- R9: A received data bit with no transmit data pending is answered by an ACK at the first edge after `tx_ready` rises. `ack_delay` has no effect on this case.
- R10: A received ACK with no transmit data pending is answered by an ACK `ack_delay` cycles later than in R9. With `ack_delay`=0 there is no added wait.
- R11: If `tx_valid` rises while an ACK is being held back by the delay, the data bit is sent at the next edge.
- R12: Exactly one symbol is sent per symbol received. After the reply, `tx_ready` is 0 and `tx_wires` holds until the next reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_delay | input | DLY_W | Extra cycles to wait before answering an ACK with an ACK |
| tx_valid | input | 1 | A data bit is offered for sending |
| tx_bit | input | 1 | Value of the offered data bit |
| tx_ready | output | 1 | A reply is owed; the offered bit is taken this cycle |
| tx_wires | output | 2 | Outgoing wire pair |
| rx_wires | input | 2 | Incoming wire pair (asynchronous) |
| rx_valid | output | 1 | One-cycle pulse: a data bit was received |
| rx_bit | output | 1 | Value of the received bit, valid with `rx_valid` |
| rx_ack | output | 1 | One-cycle pulse: an ACK was received |

## Verification
An input-wire change driven between edges reaches the receive strobes after the third rising edge: two edges in the synchroniser and one in the strobe register. The bench checks the strobes at the negative edge after the second rising edge, where they must still be 0, and again after the third, where they must be set. The reply is due one edge later. For an ACK answering an ACK, it is due `ack_delay` edges after that. The bench checks that `tx_wires` has not moved in every cycle before the due edge, then checks the expected toggle pattern just after it. All inputs are driven and all outputs sampled on the falling edge, half a period away from the active edge.

// File: rtl/tcl_pkg.sv
package tcl_pkg;

    localparam int LINK_W = 2;

    // Transition pattern on a wire pair: which wires flip.
    typedef enum logic [LINK_W-1:0] {
        SYM_NONE = 2'b00,
        SYM_BIT0 = 2'b01,
        SYM_BIT1 = 2'b10,
        SYM_ACK  = 2'b11
    } sym_e;

    typedef struct packed {
        logic valid;
        sym_e code;
    } rx_evt_t;

    function automatic sym_e bit_to_sym(input logic b);
        return b ? SYM_BIT1 : SYM_BIT0;
    endfunction

    function automatic logic sym_is_bit(input sym_e s);
        return (s == SYM_BIT0) || (s == SYM_BIT1);
    endfunction

endpackage

// File: rtl/tcl_sync.sv
module tcl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tcl_rx_decode.sv
module tcl_rx_decode
    import tcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINK_W-1:0] lvl,
    output rx_evt_t           evt,
    output logic              rx_valid,
    output logic              rx_bit,
    output logic              rx_ack
);
    logic [LINK_W-1:0] prev_q;
    sym_e              diff;

    assign diff      = sym_e'(lvl ^ prev_q);
    assign evt.valid = (diff != SYM_NONE);
    assign evt.code  = diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            rx_valid <= 1'b0;
            rx_bit   <= 1'b0;
            rx_ack   <= 1'b0;
        end else begin
            prev_q   <= lvl;
            rx_valid <= sym_is_bit(diff);
            rx_bit   <= (diff == SYM_BIT1);
            rx_ack   <= (diff == SYM_ACK);
        end
    end

    // R6: a received ACK never also reports a data bit
    a_r6_ack_excludes_bit: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_ack));

    // R5: a strobe is only raised for a change the synchroniser delivered
    a_r5_strobe_from_change: assert property (@(posedge clk) disable iff (rst)
        (rx_valid || rx_ack) |-> ($past(lvl) != $past(prev_q)));
endmodule

// File: rtl/tcl_tx_sched.sv
module tcl_tx_sched
    import tcl_pkg::*;
#(
    parameter bit FIRST_TURN = 1'b1,
    parameter int DLY_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_evt_t           evt,
    input  logic [DLY_W-1:0]  ack_delay,
    input  logic              tx_valid,
    input  logic              tx_bit,
    output logic              tx_ready,
    output logic [LINK_W-1:0] tx_wires
);
    logic              owe_q;
    logic              peer_ack_q;
    logic [DLY_W-1:0]  cnt_q;
    logic [LINK_W-1:0] wires_q;

    logic data_fire, hold, ack_fire;
    sym_e send_code;

    assign data_fire = owe_q && tx_valid;
    assign hold      = peer_ack_q && (cnt_q < ack_delay);
    assign ack_fire  = owe_q && !tx_valid && !hold;
    assign send_code = data_fire ? bit_to_sym(tx_bit)
                     : (ack_fire ? SYM_ACK : SYM_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            owe_q      <= FIRST_TURN;
            peer_ack_q <= 1'b0;
            cnt_q      <= '0;
            wires_q    <= '0;
        end else begin
            wires_q <= wires_q ^ send_code;
            if (evt.valid) begin
                owe_q      <= 1'b1;
                peer_ack_q <= (evt.code == SYM_ACK);
                cnt_q      <= '0;
            end else if (data_fire || ack_fire) begin
                owe_q <= 1'b0;
            end else if (owe_q && hold) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tx_ready = owe_q;
    assign tx_wires = wires_q;

    // R4: the wires move only when a reply was owed
    a_r4_send_only_when_owed: assert property (@(posedge clk) disable iff (rst)
        !$stable(wires_q) |-> $past(owe_q));

    // R8: pending data is never displaced by an ACK
    a_r8_data_before_ack: assert property (@(posedge clk) disable iff (rst)
        (owe_q && tx_valid) |=> ((wires_q ^ $past(wires_q)) != SYM_ACK));

    // R2: a data bit flips exactly one wire
    a_r2_bit_one_wire: assert property (@(posedge clk) disable iff (rst)
        (owe_q && tx_valid) |=> ($countones(wires_q ^ $past(wires_q)) == 1));

    // R10: an ACK answering an ACK waits out the delay
    a_r10_ack_held: assert property (@(posedge clk) disable iff (rst)
        (owe_q && !tx_valid && peer_ack_q && (cnt_q < ack_delay)) |=> $stable(wires_q));

    // R12: after a symbol leaves, nothing more is owed unless a new one arrived
    a_r12_one_reply: assert property (@(posedge clk) disable iff (rst)
        (!$stable(wires_q) && !$past(evt.valid)) |-> !owe_q);
endmodule

// File: rtl/tclink_endpoint.sv
module tclink_endpoint
    import tcl_pkg::*;
#(
    parameter bit FIRST_TURN  = 1'b1,
    parameter int DLY_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DLY_W-1:0]  ack_delay,
    input  logic              tx_valid,
    input  logic              tx_bit,
    output logic              tx_ready,
    output logic [LINK_W-1:0] tx_wires,
    input  logic [LINK_W-1:0] rx_wires,
    output logic              rx_valid,
    output logic              rx_bit,
    output logic              rx_ack
);
    logic [LINK_W-1:0] rx_lvl;
    rx_evt_t           evt;

    tcl_sync #(.W(LINK_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_wires),
        .q   (rx_lvl)
    );

    tcl_rx_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .lvl      (rx_lvl),
        .evt      (evt),
        .rx_valid (rx_valid),
        .rx_bit   (rx_bit),
        .rx_ack   (rx_ack)
    );

    tcl_tx_sched #(.FIRST_TURN(FIRST_TURN), .DLY_W(DLY_W)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .ack_delay (ack_delay),
        .tx_valid  (tx_valid),
        .tx_bit    (tx_bit),
        .tx_ready  (tx_ready),
        .tx_wires  (tx_wires)
    );

    // R7: a reply becomes owed together with the receive strobe
    a_r7_owe_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (rx_valid || rx_ack) |-> tx_ready);
endmodule

// File: tb/test_tclink_endpoint.sv
`timescale 1ns/1ps
module test_tclink_endpoint;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] ack_delay;
    logic       tx_valid, tx_bit, tx_ready;
    logic [1:0] tx_wires, rx_wires;
    logic       rx_valid, rx_bit, rx_ack;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tclink_endpoint i_tclink_endpoint (
        .clk(clk), .rst(rst), .ack_delay(ack_delay),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
        .tx_wires(tx_wires), .rx_wires(rx_wires),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_ack(rx_ack)
    );

    // fields: peer code[13:12], has data[11], bit[10], delay[9:6], reply code[5:4], latency[3:0]
    localparam int NV = 8;
    localparam logic [13:0] VEC [NV] = '{
        {2'b01, 1'b0, 1'b0, 4'd3, 2'b11, 4'd1},
        {2'b10, 1'b1, 1'b0, 4'd3, 2'b01, 4'd1},
        {2'b11, 1'b0, 1'b0, 4'd0, 2'b11, 4'd1},
        {2'b11, 1'b0, 1'b0, 4'd2, 2'b11, 4'd3},
        {2'b11, 1'b1, 1'b1, 4'd5, 2'b10, 4'd1},
        {2'b10, 1'b1, 1'b1, 4'd0, 2'b10, 4'd1},
        {2'b11, 1'b0, 1'b0, 4'd5, 2'b11, 4'd6},
        {2'b01, 1'b0, 1'b0, 4'd7, 2'b11, 4'd1}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [13:0] v);
        logic [1:0] code, expc, old;
        logic       has, b;
        int         lat;
        string      rtag, ttag;
        code = v[13:12]; has = v[11]; b = v[10];
        expc = v[5:4];   lat = int'(v[3:0]);
        rtag = (code == 2'b11) ? "R6" : "R5";
        ttag = has ? (b ? "R2 R8 bit1" : "R2 R8 bit0")
             : ((code == 2'b11) ? "R3 R10" : "R3 R9");
        ack_delay = v[9:6];
        old       = tx_wires;
        rx_wires  = rx_wires ^ code;
        tx_valid  = has;
        tx_bit    = b;
        @(negedge clk);
        @(negedge clk);
        chk(!rx_valid && !rx_ack, {rtag, " early strobe"}, {rx_valid, rx_ack}, 0);
        @(negedge clk);
        if (code == 2'b11) begin
            chk(rx_ack && !rx_valid, "R6 ack strobe", {rx_valid, rx_ack}, 1);
        end else begin
            chk(rx_valid && !rx_ack && (rx_bit == code[1]), "R5 bit strobe",
                {rx_valid, rx_ack, rx_bit}, {2'b10, code[1]});
        end
        chk(tx_ready == 1'b1, "R7 reply owed", tx_ready, 1);
        chk(tx_wires == old, {ttag, " too early"}, tx_wires, old);
        for (int i = 1; i < lat; i++) begin
            @(negedge clk);
            chk(tx_wires == old, {ttag, " too early"}, tx_wires, old);
        end
        @(negedge clk);
        chk(tx_wires == (old ^ expc), {ttag, " reply"}, tx_wires, old ^ expc);
        chk(!tx_ready && !rx_valid && !rx_ack, "R12 one reply, one-cycle strobe",
            {tx_ready, rx_valid, rx_ack}, 0);
        tx_valid = 1'b0;
    endtask

    initial begin
        logic [1:0] old;
        rst = 1'b1; rx_wires = 2'b00; tx_valid = 1'b0; tx_bit = 1'b0; ack_delay = 4'd0;
        repeat (3) @(negedge clk);
        chk(tx_wires == 2'b00, "R1 wires", tx_wires, 0);
        chk(!rx_valid && !rx_ack, "R1 strobes", {rx_valid, rx_ack}, 0);
        chk(tx_ready == 1'b1, "R1 first turn", tx_ready, 1);
        rst = 1'b0;

        // first turn: send bit 1
        tx_valid = 1'b1; tx_bit = 1'b1;
        @(negedge clk);
        chk(tx_wires == 2'b10, "R2 first bit1", tx_wires, 2'b10);
        chk(tx_ready == 1'b0, "R12 first done", tx_ready, 0);

        // R4: data offered while nothing owed
        tx_bit = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk(tx_wires == 2'b10 && !tx_ready, "R4 no send when not owed",
                {tx_ready, tx_wires}, 3'b010);
        end
        tx_valid = 1'b0;

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R11: data cuts short a pending ACK delay
        ack_delay = 4'd8;
        old       = tx_wires;
        rx_wires  = rx_wires ^ 2'b11;
        repeat (3) @(negedge clk);
        chk(rx_ack == 1'b1, "R6 ack before R11", rx_ack, 1);
        repeat (2) @(negedge clk);
        chk(tx_wires == old, "R10 delay holding", tx_wires, old);
        tx_valid = 1'b1; tx_bit = 1'b0;
        @(negedge clk);
        chk(tx_wires == (old ^ 2'b01), "R11 data pre-empts delay", tx_wires, old ^ 2'b01);
        tx_valid = 1'b0;

        // R12: quiet until the peer sends again
        old = tx_wires;
        repeat (10) @(negedge clk);
        chk(tx_wires == old && !tx_ready, "R12 quiet after reply",
            {tx_ready, tx_wires}, {1'b0, old});

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule